// File: doc/BRIEF.md
# Multi-Link Cell Ingress Controller

This block sits behind a set of per-link receive queues. Each link delivers fixed-size cells as 32-bit words. The block turns those cells into one ordered stream of payload words for user logic. A configuration input picks a bundle of either two links or eight links. Before any cell is forwarded, the block brings the links of the bundle into line on a common sequence number. After that it takes whole cells in turn from the links that hold one.

Each cell is loaded into a local buffer. While it loads, the block computes a BIP-8 over the payload and then checks it against the header. It also checks the header's sequence number against the value that link should send next. A cell that fails either check is discarded. Each of the two discard rules has its own disable input. The block also reports queue overrun for each link with a sticky flag, which is cleared by a one-cycle pulse.

The mode input is meant to change only while reset is held.

Top module: `cell_ingress_ctrl`

## Requirements
- R1: After reset, `out_valid` is low, `aligned` is low and every bit of `ovr_flag` is low.
- R2: The first word of a cell is its header: bits [31:24] hold the sequence number, bits [23:16] the BIP-8 and bits [15:0] the header field. A forwarded cell appears as its CELL_WORDS-1 payload words, in the order received, on consecutive cycles with `out_valid` high. `out_hdr` carries the header field and `out_link` the source link. `out_sop` is high only with the first payload word and `out_eop` only with the last.
- R3: With `mode_eight`=0 only links 0 and 1 are read. With `mode_eight`=1 links 0 to 7 are read. A link outside the bundle never shows up on `out_link`.
- R4: No cell is forwarded until every link in the bundle holds a complete cell at its head and all those heads carry the same sequence number. While they differ, the head cell of a link whose sequence number is below the largest head sequence number is read and discarded. `aligned` rises once the heads match and stays high until reset.
- R5: After alignment, cells are taken one whole cell at a time in rotation. The rotation starts at link 0 after reset. Any link that does not hold a complete cell is skipped.
- R6: The BIP-8 is the XOR of all payload bytes of the cell. A mismatch with the header BIP drops the cell unless `bip_drop_off` is high, in which case the cell is forwarded.
- R7: Each link expects its sequence number to rise by one from cell to cell, wrapping from 255 to 0. A mismatch drops the cell unless `seq_drop_off` is high. After every checked cell, the link's expected number becomes the received number plus one.
- R8: A write to a link whose queue holds FIFO_DEPTH words is lost and sets that link's `ovr_flag` bit. Exactly FIFO_DEPTH writes do not set the flag. The bit stays set until a one-cycle pulse on that link's `ovr_clr` bit.
- R9: A dropped cell is still removed from its queue and produces no `out_valid`, `out_sop` or `out_eop`. The next cell from that link is checked normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_eight | input | 1 | 0: two-link bundle (links 0,1); 1: eight-link bundle |
| bip_drop_off | input | 1 | High keeps cells whose BIP-8 mismatches |
| seq_drop_off | input | 1 | High keeps cells whose sequence number mismatches |
| link_wr_en | input | NLINKS | Per-link write strobe into its receive queue |
| link_wr_data | input | NLINKS*32 | Per-link write word, link n at bits [32n+31:32n] |
| ovr_clr | input | NLINKS | Per-link write-one-to-clear pulse for the overrun flag |
| ovr_flag | output | NLINKS | Per-link sticky overrun flag |
| aligned | output | 1 | Bundle alignment reached |
| out_valid | output | 1 | Payload word valid |
| out_sop | output | 1 | First payload word of a cell |
| out_eop | output | 1 | Last payload word of a cell |
| out_link | output | log2(NLINKS) | Source link of the current cell |
| out_hdr | output | 16 | Header field of the current cell |
| out_data | output | 32 | Payload word |

## Verification
The bench starts with the two links out of step by two sequence numbers. A controller that forwarded before the heads matched, or that discarded from the wrong link, would emit the stale cells or lose the good ones. It sends bad-BIP cells and sequence skips with each disable both low and high, and includes a wrap from 255 to 0. A wrong resync rule would then drop the cell that follows a skip, and a wrong parity span would drop good cells. It fills an unread queue to exactly its depth and then one word more, which catches an off-by-one full test or a flag that clears itself. A full eight-link load checks that the rotation visits links 0 to 7 twice in order and that a single ready link is not blocked by empty ones.

// File: rtl/cig_pkg.sv
package cig_pkg;
  localparam int WORD_W  = 32;
  localparam int HDR_W   = 16;
  localparam int SEQ_LSB = 24;
  localparam int BIP_LSB = 16;

  typedef enum logic [1:0] {ST_PICK, ST_LOAD, ST_CHECK, ST_EMIT} cig_state_e;

  function automatic logic [7:0] byte_xor(input logic [WORD_W-1:0] w);
    return w[31:24] ^ w[23:16] ^ w[15:8] ^ w[7:0];
  endfunction
endpackage

// File: rtl/cig_link_fifo.sv
module cig_link_fifo #(
  parameter int DEPTH = 32,
  parameter int W     = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [W-1:0]               wr_data,
  input  logic                       rd_en,
  input  logic                       ovr_clr,
  output logic [W-1:0]               head,
  output logic [$clog2(DEPTH+1)-1:0] occ,
  output logic                       ovr_flag
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int OW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [OW-1:0] occ_q, occ_d;
  logic          ovr_q, ovr_d;
  logic          full, push, pop;

  always_comb begin
    full  = (occ_q == OW'(DEPTH));
    push  = wr_en && !full;
    pop   = rd_en && (occ_q != '0);
    wp_d  = wp_q;
    rp_d  = rp_q;
    if (push) wp_d = (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
    if (pop)  rp_d = (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
    occ_d = occ_q + OW'(push) - OW'(pop);
    ovr_d = ovr_q;
    if (ovr_clr)        ovr_d = 1'b0;
    if (wr_en && full)  ovr_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      occ_q <= '0;
      ovr_q <= 1'b0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      occ_q <= occ_d;
      ovr_q <= ovr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp_q] <= wr_data;
  end

  assign head     = mem[rp_q];
  assign occ      = occ_q;
  assign ovr_flag = ovr_q;

  p_read_nonempty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (occ_q != '0));
  p_ovr_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full) |=> ovr_flag);
  p_ovr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_flag && !ovr_clr) |=> ovr_flag);
  p_occ_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    occ_q <= OW'(DEPTH));
endmodule

// File: rtl/cig_cell_buf.sv
module cig_cell_buf
  import cig_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic                  clk,
  input  logic                  ld_en,
  input  logic [$clog2(CW)-1:0] ld_idx,
  input  logic [WORD_W-1:0]     ld_data,
  input  logic [$clog2(CW)-1:0] rd_idx,
  output logic [WORD_W-1:0]     rd_data,
  output logic [WORD_W-1:0]     hdr_word,
  output logic [7:0]            bip_sum
);
  logic [WORD_W-1:0] cell_mem [CW];
  logic [7:0]        acc_q, acc_d;

  always_comb begin
    acc_d = acc_q;
    if (ld_en) acc_d = (ld_idx == '0) ? 8'h00 : (acc_q ^ byte_xor(ld_data));
  end

  always_ff @(posedge clk) begin
    if (ld_en) cell_mem[ld_idx] <= ld_data;
    acc_q <= acc_d;
  end

  assign rd_data  = cell_mem[rd_idx];
  assign hdr_word = cell_mem[0];
  assign bip_sum  = acc_q;
endmodule

// File: rtl/cell_ingress_ctrl.sv
module cell_ingress_ctrl
  import cig_pkg::*;
#(
  parameter int NLINKS     = 8,
  parameter int PAIR_LINKS = 2,
  parameter int CELL_WORDS = 16,
  parameter int FIFO_DEPTH = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      mode_eight,
  input  logic                      bip_drop_off,
  input  logic                      seq_drop_off,
  input  logic [NLINKS-1:0]         link_wr_en,
  input  logic [NLINKS*WORD_W-1:0]  link_wr_data,
  input  logic [NLINKS-1:0]         ovr_clr,
  output logic [NLINKS-1:0]         ovr_flag,
  output logic                      aligned,
  output logic                      out_valid,
  output logic                      out_sop,
  output logic                      out_eop,
  output logic [$clog2(NLINKS)-1:0] out_link,
  output logic [HDR_W-1:0]          out_hdr,
  output logic [WORD_W-1:0]         out_data
);
  localparam int LW = $clog2(NLINKS);
  localparam int IW = $clog2(CELL_WORDS);
  localparam int OW = $clog2(FIFO_DEPTH + 1);
  localparam logic [IW-1:0] LAST_IDX = IW'(CELL_WORDS - 1);

  // reset: asserted asynchronously, released after two clocks
  logic rs1_q, rs2_q, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_s = rs2_q;

  logic [NLINKS-1:0] en_mask, ready, rd_en;
  logic [WORD_W-1:0] head [NLINKS];
  logic [OW-1:0]     occ  [NLINKS];
  logic [7:0]        head_seq [NLINKS];

  assign en_mask = mode_eight ? {NLINKS{1'b1}}
                              : {{(NLINKS-PAIR_LINKS){1'b0}}, {PAIR_LINKS{1'b1}}};

  for (genvar g = 0; g < NLINKS; g++) begin : g_link
    cig_link_fifo #(.DEPTH(FIFO_DEPTH), .W(WORD_W)) u_fifo (
      .clk      (clk),
      .rst_n    (rst_s),
      .wr_en    (link_wr_en[g]),
      .wr_data  (link_wr_data[g*WORD_W +: WORD_W]),
      .rd_en    (rd_en[g]),
      .ovr_clr  (ovr_clr[g]),
      .head     (head[g]),
      .occ      (occ[g]),
      .ovr_flag (ovr_flag[g])
    );
    assign ready[g]    = en_mask[g] && (occ[g] >= OW'(CELL_WORDS));
    assign head_seq[g] = head[g][SEQ_LSB +: 8];
  end

  cig_state_e        state_q, state_d;
  logic [LW-1:0]     cur_q, cur_d, last_q, last_d;
  logic [IW-1:0]     cnt_q, cnt_d;
  logic              discard_q, discard_d, aligned_q, aligned_d;
  logic [7:0]        exp_q [NLINKS];
  logic [7:0]        exp_d [NLINKS];

  logic [WORD_W-1:0] buf_rd, hdr_word;
  logic [7:0]        bip_sum, hdr_seq, max_seq;
  logic              ld_en, all_ready, all_eq, any_rdy, bip_err, seq_err, keep;
  logic [LW-1:0]     behind, pick;

  // alignment search over the heads of the enabled links
  always_comb begin
    logic found;
    max_seq = 8'h00;
    for (int l = 0; l < NLINKS; l++)
      if (en_mask[l] && head_seq[l] > max_seq) max_seq = head_seq[l];
    all_eq = 1'b1;
    behind = '0;
    found  = 1'b0;
    for (int l = 0; l < NLINKS; l++) begin
      if (en_mask[l] && head_seq[l] != max_seq) begin
        all_eq = 1'b0;
        if (!found) begin
          behind = LW'(l);
          found  = 1'b1;
        end
      end
    end
    all_ready = &(ready | ~en_mask);
  end

  // rotation: first ready link after the last one served
  always_comb begin
    int j;
    pick    = '0;
    any_rdy = 1'b0;
    for (int off = 1; off <= NLINKS; off++) begin
      j = int'(last_q) + off;
      if (j >= NLINKS) j = j - NLINKS;
      if (!any_rdy && ready[j]) begin
        pick    = LW'(j);
        any_rdy = 1'b1;
      end
    end
  end

  assign hdr_seq = hdr_word[SEQ_LSB +: 8];
  assign bip_err = (bip_sum != hdr_word[BIP_LSB +: 8]);
  assign seq_err = (hdr_seq != exp_q[cur_q]);
  assign keep    = !(bip_err && !bip_drop_off) && !(seq_err && !seq_drop_off);

  always_comb begin
    state_d   = state_q;
    cur_d     = cur_q;
    last_d    = last_q;
    cnt_d     = cnt_q;
    discard_d = discard_q;
    aligned_d = aligned_q;
    exp_d     = exp_q;
    unique case (state_q)
      ST_PICK: begin
        if (!aligned_q) begin
          if (all_ready) begin
            if (all_eq) begin
              aligned_d = 1'b1;
              for (int l = 0; l < NLINKS; l++)
                if (en_mask[l]) exp_d[l] = max_seq;
            end else begin
              state_d   = ST_LOAD;
              cur_d     = behind;
              cnt_d     = '0;
              discard_d = 1'b1;
            end
          end
        end else if (any_rdy) begin
          state_d   = ST_LOAD;
          cur_d     = pick;
          last_d    = pick;
          cnt_d     = '0;
          discard_d = 1'b0;
        end
      end
      ST_LOAD: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == LAST_IDX) begin
          state_d = ST_CHECK;
          cnt_d   = '0;
        end
      end
      ST_CHECK: begin
        state_d = ST_PICK;
        if (!discard_q) begin
          exp_d[cur_q] = hdr_seq + 8'd1;
          if (keep) begin
            state_d = ST_EMIT;
            cnt_d   = IW'(1);
          end
        end
      end
      ST_EMIT: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == LAST_IDX) state_d = ST_PICK;
      end
      default: state_d = ST_PICK;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      state_q   <= ST_PICK;
      cur_q     <= '0;
      last_q    <= LW'(NLINKS - 1);
      cnt_q     <= '0;
      discard_q <= 1'b0;
      aligned_q <= 1'b0;
      for (int l = 0; l < NLINKS; l++) exp_q[l] <= 8'h00;
    end else begin
      state_q   <= state_d;
      cur_q     <= cur_d;
      last_q    <= last_d;
      cnt_q     <= cnt_d;
      discard_q <= discard_d;
      aligned_q <= aligned_d;
      exp_q     <= exp_d;
    end
  end

  assign ld_en = (state_q == ST_LOAD);
  for (genvar g = 0; g < NLINKS; g++) begin : g_rd
    assign rd_en[g] = ld_en && (cur_q == LW'(g));
  end

  cig_cell_buf #(.CW(CELL_WORDS)) u_buf (
    .clk      (clk),
    .ld_en    (ld_en),
    .ld_idx   (cnt_q),
    .ld_data  (head[cur_q]),
    .rd_idx   (cnt_q),
    .rd_data  (buf_rd),
    .hdr_word (hdr_word),
    .bip_sum  (bip_sum)
  );

  assign aligned   = aligned_q;
  assign out_valid = (state_q == ST_EMIT);
  assign out_sop   = out_valid && (cnt_q == IW'(1));
  assign out_eop   = out_valid && (cnt_q == LAST_IDX);
  assign out_link  = cur_q;
  assign out_hdr   = hdr_word[HDR_W-1:0];
  assign out_data  = buf_rd;

  p_fwd_aligned_r4: assert property (@(posedge clk) disable iff (!rst_s)
    out_valid |-> aligned);
  p_fwd_enabled_r3: assert property (@(posedge clk) disable iff (!rst_s)
    out_valid |-> en_mask[out_link]);
  p_single_reader_r5: assert property (@(posedge clk) disable iff (!rst_s)
    $onehot0(rd_en));
  p_gap_after_eop_r2: assert property (@(posedge clk) disable iff (!rst_s)
    out_eop |=> !out_valid);
  p_bip_drop_r6: assert property (@(posedge clk) disable iff (!rst_s)
    (state_q == ST_CHECK && !discard_q && bip_err && !bip_drop_off) |=> !out_valid);
  p_seq_drop_r7: assert property (@(posedge clk) disable iff (!rst_s)
    (state_q == ST_CHECK && !discard_q && seq_err && !seq_drop_off) |=> !out_valid);
endmodule

// File: tb/cell_ingress_ctrl_test.sv
module cell_ingress_ctrl_test;
  localparam int NL  = 8;
  localparam int CW  = 4;
  localparam int DEP = 32;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n, mode_eight, bip_drop_off, seq_drop_off;
  logic [NL-1:0] link_wr_en, ovr_clr, ovr_flag;
  logic [NL*32-1:0] link_wr_data;
  logic          aligned, out_valid, out_sop, out_eop;
  logic [2:0]    out_link;
  logic [15:0]   out_hdr;
  logic [31:0]   out_data;

  cell_ingress_ctrl #(.NLINKS(NL), .PAIR_LINKS(2), .CELL_WORDS(CW), .FIFO_DEPTH(DEP)) uut (
    .clk(clk), .rst_n(rst_n), .mode_eight(mode_eight), .bip_drop_off(bip_drop_off),
    .seq_drop_off(seq_drop_off), .link_wr_en(link_wr_en), .link_wr_data(link_wr_data),
    .ovr_clr(ovr_clr), .ovr_flag(ovr_flag), .aligned(aligned), .out_valid(out_valid),
    .out_sop(out_sop), .out_eop(out_eop), .out_link(out_link), .out_hdr(out_hdr),
    .out_data(out_data));

  int tests = 0, fails = 0, cells_out = 0, widx = 0;
  logic [47:0] exp_q [NL][$];
  int order [$];

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  function automatic logic [31:0] pay(int l, int seq, int i);
    return {4'(l), 4'(i), 8'(seq), 8'h5A, 8'(seq) ^ 8'h33};
  endfunction
  function automatic logic [15:0] hfld(int l, int seq);
    return {8'(l) + 8'h10, 8'(seq)};
  endfunction
  function automatic logic [7:0] bipc(int l, int seq);
    logic [7:0] b = 8'h00;
    for (int i = 1; i < CW; i++) begin
      logic [31:0] w = pay(l, seq, i);
      b = b ^ w[31:24] ^ w[23:16] ^ w[15:8] ^ w[7:0];
    end
    return b;
  endfunction
  function automatic logic [31:0] hword(int l, int seq, bit bad);
    return {8'(seq), bipc(l, seq) ^ {7'd0, bad}, hfld(l, seq)};
  endfunction

  task automatic push_exp(int l, int seq);
    for (int i = 1; i < CW; i++) exp_q[l].push_back({hfld(l, seq), pay(l, seq, i)});
  endtask

  task automatic send(int l, int seq, bit bad, bit fwd);
    if (fwd) push_exp(l, seq);
    for (int i = 0; i < CW; i++) begin
      @(negedge clk);
      link_wr_en = '0;
      link_wr_en[l] = 1'b1;
      link_wr_data[l*32 +: 32] = (i == 0) ? hword(l, seq, bad) : pay(l, seq, i);
    end
    @(negedge clk);
    link_wr_en = '0;
  endtask

  task automatic send_par(logic [NL-1:0] mask, int seq);
    for (int l = 0; l < NL; l++) if (mask[l]) push_exp(l, seq);
    for (int i = 0; i < CW; i++) begin
      @(negedge clk);
      link_wr_en = mask;
      for (int l = 0; l < NL; l++)
        link_wr_data[l*32 +: 32] = (i == 0) ? hword(l, seq, 1'b0) : pay(l, seq, i);
    end
    @(negedge clk);
    link_wr_en = '0;
  endtask

  task automatic do_reset(bit eight);
    rst_n = 1'b0;
    link_wr_en = '0; link_wr_data = '0; ovr_clr = '0;
    bip_drop_off = 1'b0; seq_drop_off = 1'b0; mode_eight = eight;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cells_out = 0; widx = 0; order.delete();
  endtask

  // output monitor
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      logic [47:0] e;
      chk(out_sop == (widx == 0), "R2", "sop strobe", out_sop, widx == 0);
      chk(out_eop == (widx == CW - 2), "R2", "eop strobe", out_eop, widx == CW - 2);
      if (!mode_eight) chk(out_link < 2, "R3", "link outside bundle", out_link, 1);
      if (exp_q[out_link].size() == 0) begin
        chk(1'b0, "R9", "unexpected word", out_data, 0);
      end else begin
        e = exp_q[out_link].pop_front();
        chk({out_hdr, out_data} == e, "R2", "hdr/payload", {out_hdr, out_data}, e);
      end
      if (out_sop) begin
        order.push_back(int'(out_link));
        cells_out++;
      end
      widx = out_eop ? 0 : widx + 1;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    tests++; fails++;
    $display("FAIL R5 watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    // R1 reset state
    do_reset(1'b0);
    chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    chk(aligned == 1'b0, "R1", "aligned after reset", aligned, 0);
    chk(ovr_flag == '0, "R1", "ovr_flag after reset", ovr_flag, 0);

    // R4 alignment in two-link mode: link1 two cells behind
    send(1, 3, 0, 0);
    send(1, 4, 0, 0);
    send(0, 5, 0, 1);
    repeat (40) @(negedge clk);
    chk(aligned == 1'b0, "R4", "aligned before heads match", aligned, 0);
    chk(cells_out == 0, "R4", "cells before alignment", cells_out, 0);
    send(2, 9, 0, 0);          // R3: link 2 outside two-link bundle
    send(1, 5, 0, 1);
    send(0, 6, 0, 1);
    send(1, 6, 0, 1);
    repeat (150) @(negedge clk);
    chk(aligned == 1'b1, "R4", "aligned after heads match", aligned, 1);
    chk(cells_out == 4, "R4", "cells after alignment", cells_out, 4);

    // R6 BIP drop and its disable
    send(0, 7, 1, 0);
    send(0, 8, 0, 1);
    repeat (30) @(negedge clk);
    bip_drop_off = 1'b1;
    send(0, 9, 1, 1);
    repeat (30) @(negedge clk);
    bip_drop_off = 1'b0;
    chk(cells_out == 6, "R6", "cells after BIP cases", cells_out, 6);

    // R7 sequence drop, resync, disable and wrap; R9 consumption
    send(1, 7, 0, 1);
    send(1, 9, 0, 0);
    send(1, 10, 0, 1);
    repeat (60) @(negedge clk);
    chk(cells_out == 8, "R7", "cells after seq skip", cells_out, 8);
    seq_drop_off = 1'b1;
    send(0, 255, 0, 1);
    repeat (30) @(negedge clk);
    seq_drop_off = 1'b0;
    send(0, 0, 0, 1);
    send(0, 2, 0, 0);
    send(0, 3, 0, 1);
    repeat (80) @(negedge clk);
    chk(cells_out == 11, "R7", "cells after wrap and resync", cells_out, 11);
    for (int l = 0; l < NL; l++)
      chk(exp_q[l].size() == 0, "R9", "words left unmatched", exp_q[l].size(), 0);

    // R8 overrun on an unread link
    for (int i = 0; i < DEP; i++) begin
      @(negedge clk);
      link_wr_en = 8'h80;
      link_wr_data[7*32 +: 32] = 32'(i);
    end
    @(negedge clk);
    link_wr_en = '0;
    chk(ovr_flag == '0, "R8", "flag after exactly depth writes", ovr_flag, 0);
    link_wr_en = 8'h80;
    @(negedge clk);
    link_wr_en = '0;
    chk(ovr_flag == 8'h80, "R8", "flag after overflow write", ovr_flag, 8'h80);
    repeat (5) @(negedge clk);
    chk(ovr_flag == 8'h80, "R8", "flag held", ovr_flag, 8'h80);
    ovr_clr = 8'h80;
    @(negedge clk);
    ovr_clr = '0;
    chk(ovr_flag == '0, "R8", "flag after clear pulse", ovr_flag, 0);

    // R5 rotation in eight-link mode
    do_reset(1'b1);
    send_par(8'hFF, 40);
    send_par(8'hFF, 41);
    repeat (250) @(negedge clk);
    chk(aligned == 1'b1, "R4", "eight-link aligned", aligned, 1);
    chk(cells_out == 16, "R3", "eight-link cell count", cells_out, 16);
    for (int k = 0; k < 16; k++)
      chk(k < order.size() && order[k] == k % 8, "R5", "rotation order",
          (k < order.size()) ? order[k] : -1, k % 8);
    send(3, 42, 0, 1);
    repeat (40) @(negedge clk);
    chk(order.size() == 17 && order[16] == 3, "R5", "lone ready link served",
        (order.size() == 17) ? order[16] : -1, 3);
    for (int l = 0; l < NL; l++)
      chk(exp_q[l].size() == 0, "R2", "eight-link words left", exp_q[l].size(), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule